// File: doc/BRIEF.md
# SD Host Receive Byte FIFO with Access-Width Flags

This block buffers bytes arriving from the data lines of an SD/SDIO card and hands them to a CPU or DMA read port. The card side pushes one byte per cycle. The read side pops a word of 1, 2 or 4 bytes per read. The host sets that width with a select input. The read data is presented combinationally while the read strobe is high. The occupancy moves on the following clock edge.

The full and empty flags do not track single entries. They tell the reader, or the card-side writer, whether a whole access of the chosen width fits. A receive-ready flag asks for a DMA read or an interrupt when the occupancy reaches the trigger level, which is either half the buffer or the whole buffer. The block also holds the byte count of the current transfer. When the last byte of the transfer has arrived, ready is raised for whatever remains, so a tail shorter than the trigger level is still drained. A done flag marks the arrival of that last byte. A push into a buffer with no free entry is dropped and sets a sticky overrun flag.

Top module: `sd_rx_fifo`

## Requirements
- R1: After reset the occupancy is 0. empty=1, full=0, rx_ready=0, xfer_done=0 and overrun=0.
- R2: empty is 1 exactly when the stored byte count is below the access width, and 0 otherwise.
- R3: full is 1 exactly when the free space (32 minus the stored count) is below the access width, and 0 otherwise. With a width of 4 this gives: counts 0–3 are empty only, counts 4–28 are neither, counts 29–32 are full only.
- R4: Bytes leave in arrival order. The oldest byte goes in bits 7:0, the next in bits 15:8, and so on up to the access width. A read pops that many bytes.
- R5: A read when fewer bytes than the access width are stored returns the stored bytes in the low lanes. The upper lanes are zero, and the FIFO is left empty.
- R6: rx_ready is 1 whenever the occupancy is at or above the trigger level: 16 bytes when trig_sel=0, 32 bytes when trig_sel=1.
- R7: Once every byte of the programmed transfer length has been pushed, rx_ready is 1 while any byte is still stored, whatever the trigger level.
- R8: xfer_start loads xfer_len and clears xfer_done. xfer_done becomes 1 on the clock edge that accepts the last byte of that length, and stays 1.
- R9: A push while 32 bytes are stored is dropped and sets overrun. overrun stays set until a cycle with ovr_clr=1.
- R10: width_sel encodes the access width as 0→1 byte, 1→2 bytes, 2→4 bytes and 3→4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_sel | input | 2 | Access width code (R10) |
| trig_sel | input | 1 | Trigger level: 0 = half buffer, 1 = full buffer |
| xfer_start | input | 1 | Load transfer length, clear done |
| xfer_len | input | 16 | Transfer length in bytes |
| push_valid | input | 1 | Card-side byte strobe |
| push_byte | input | 8 | Card-side byte |
| rd_en | input | 1 | Read one access-width word |
| rd_data | output | 32 | Read word, oldest byte in the low lane |
| ovr_clr | input | 1 | Write-one clear of overrun |
| fifo_empty | output | 1 | Fewer bytes stored than the access width |
| fifo_full | output | 1 | Less free space than the access width |
| rx_ready | output | 1 | Read request (trigger level or final remainder) |
| xfer_done | output | 1 | Whole transfer received |
| overrun | output | 1 | Sticky dropped-push flag |

## Verification
The bench fills the buffer one byte at a time for every width code and compares both flags at every occupancy with the threshold arithmetic. A design that compares against single entries, or that uses an off-by-one bound, shows an error near 0, near 32 or near 32 minus the width. Transfers of 19 and 35 bytes leave a tail of 3 bytes below the trigger. A design without the remainder rule would leave rx_ready low on that tail and never drain it. The reads of the tail check for zero padding and a true empty state, which catches a design that pops a full width or leaves stale data in the upper lanes. A push into a full buffer checks that the data is not corrupted, that the overrun flag stays set, and that it clears only on ovr_clr.

// File: rtl/sd_rx_fifo.sv
module sd_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       width_sel,
  input  logic             trig_sel,
  input  logic             xfer_start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             push_valid,
  input  logic [7:0]       push_byte,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  input  logic             ovr_clr,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic             rx_ready,
  output logic             xfer_done,
  output logic             overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt, width, nrd, trig;
  logic [LEN_W-1:0] rem;
  logic             push_ok, pop;

  assign width   = (width_sel == 2'd0) ? CW'(1) : (width_sel == 2'd1) ? CW'(2) : CW'(4);
  assign trig    = trig_sel ? FULL_CNT : HALF_CNT;
  assign nrd     = (cnt < width) ? cnt : width;
  assign push_ok = push_valid && (cnt != FULL_CNT);
  assign pop     = rd_en && (cnt != '0);

  assign fifo_empty = cnt < width;
  assign fifo_full  = (FULL_CNT - cnt) < width;
  assign rx_ready   = (cnt >= trig) || ((rem == '0) && (cnt != '0));

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign rd_data[8*i +: 8] = (CW'(i) < nrd) ? mem[AW'(rd_ptr + AW'(i))] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      rem       <= '0;
      xfer_done <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop)     rd_ptr <= rd_ptr + AW'(nrd);
      cnt <= cnt + CW'(push_ok) - (pop ? nrd : '0);
      if (xfer_start) begin
        rem       <= xfer_len;
        xfer_done <= 1'b0;
      end else if (push_ok && rem != '0) begin
        rem <= rem - 1'b1;
        if (rem == LEN_W'(1)) xfer_done <= 1'b1;
      end
      if (push_valid && !push_ok) overrun <= 1'b1;
      else if (ovr_clr)           overrun <= 1'b0;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL_CNT);
  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n) !(fifo_empty && fifo_full));
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && cnt == FULL_CNT && !rd_en |=> cnt == FULL_CNT && overrun);
  p_pop_amount_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !push_valid && cnt != '0 |=> cnt == $past(cnt) - $past(nrd));
  p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> rem == '0 && $past(push_valid));
endmodule

// File: tb/sd_rx_fifo_tb.sv
module sd_rx_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [1:0] width_sel = 0;
  logic trig_sel = 0, xfer_start = 0, push_valid = 0, rd_en = 0, ovr_clr = 0;
  logic [15:0] xfer_len = 0;
  logic [7:0] push_byte = 0;
  logic [31:0] rd_data;
  logic fifo_empty, fifo_full, rx_ready, xfer_done, overrun;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_rx_fifo dut_i (.clk(clk), .rst_n(rst_n), .width_sel(width_sel), .trig_sel(trig_sel),
    .xfer_start(xfer_start), .xfer_len(xfer_len), .push_valid(push_valid), .push_byte(push_byte),
    .rd_en(rd_en), .rd_data(rd_data), .ovr_clr(ovr_clr), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .rx_ready(rx_ready), .xfer_done(xfer_done), .overrun(overrun));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); push_valid = 1; push_byte = b;
    @(posedge clk); #1 push_valid = 0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk); rd_en = 1; #1 d = rd_data;
    @(posedge clk); #1 rd_en = 0;
  endtask

  function automatic logic [31:0] pack(input int first, input int n);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = 8'(first + i);
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int sel = 0; sel < 4; sel++) begin
      int wv, left, nxt;
      wv = (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
      width_sel = 2'(sel);
      do_reset();
      check(fifo_empty && !fifo_full && !rx_ready && !xfer_done && !overrun, "R1 reset flags",
            {fifo_empty, fifo_full, rx_ready, xfer_done, overrun}, 5'b10000);
      for (int k = 1; k <= 32; k++) begin
        push(8'(k));
        check(fifo_empty == (k < wv), "R2 empty vs width (R10 code)", fifo_empty, k < wv);
        check(fifo_full == ((32 - k) < wv), "R3 full vs width (R10 code)", fifo_full, (32 - k) < wv);
      end
      push(8'hEE);
      check(overrun == 1, "R9 overrun set", overrun, 1);
      @(negedge clk); #1;
      check(overrun == 1, "R9 overrun sticky", overrun, 1);
      ovr_clr = 1; @(posedge clk); #1 ovr_clr = 0;
      check(overrun == 0, "R9 overrun cleared", overrun, 0);
      left = 32; nxt = 1;
      while (left > 0) begin
        rd(d);
        check(d == pack(nxt, wv), "R4 read order and lanes", d, pack(nxt, wv));
        nxt += wv; left -= wv;
        check(fifo_empty == (left < wv), "R2 empty after read", fifo_empty, left < wv);
      end
    end

    for (int cfg = 0; cfg < 2; cfg++) begin
      int wv, t, len, left, nxt;
      trig_sel = cfg[0];
      width_sel = (cfg == 0) ? 2'd1 : 2'd2;
      wv = (cfg == 0) ? 2 : 4;
      t = (cfg == 0) ? 16 : 32;
      len = t + 3;
      do_reset();
      @(negedge clk); xfer_len = 16'(len); xfer_start = 1;
      @(posedge clk); #1 xfer_start = 0;
      for (int k = 1; k <= t; k++) begin
        push(8'(k));
        check(rx_ready == (k == t), "R6 trigger level", rx_ready, k == t);
      end
      left = t; nxt = 1;
      while (left > 0) begin
        rd(d);
        check(d == pack(nxt, wv), "R4 triggered read", d, pack(nxt, wv));
        nxt += wv; left -= wv;
      end
      check(rx_ready == 0, "R6 ready drops", rx_ready, 0);
      for (int k = 1; k <= 3; k++) begin
        check(xfer_done == 0, "R8 done not early", xfer_done, 0);
        push(8'(t + k));
        check(rx_ready == (k == 3), "R7 remainder ready", rx_ready, k == 3);
      end
      check(xfer_done == 1, "R8 done after last byte", xfer_done, 1);
      left = 3; nxt = t + 1;
      while (left > 0) begin
        int n;
        n = (left < wv) ? left : wv;
        rd(d);
        check(d == pack(nxt, n), "R5 partial read zero padded", d, pack(nxt, n));
        nxt += n; left -= n;
      end
      check(fifo_empty && !rx_ready, "R5 empty after tail", {fifo_empty, rx_ready}, 2'b10);
      @(negedge clk); xfer_start = 1;
      @(posedge clk); #1 xfer_start = 0;
      check(xfer_done == 0, "R8 start clears done", xfer_done, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule